// File: doc/BRIEF.md
# Five-Stage Pipelined Core for a Minimal Eight-Register ISA

This block is a 32-bit in-order scalar processor core. Each instruction passes through five stages (fetch, decode, execute, memory access and register write), with an edge-triggered register between each pair of neighbouring stages. The instruction set is small: add, bitwise nand, word load, word store, branch on equal, no-op and halt. The core works on eight general registers.

The instruction memory and the data memory are small word-addressed arrays inside the core. The program counter is a word index that steps by one. An environment fills both memories through two write ports while it holds the core in reset, then releases reset and waits for the halted flag. After that it reads the architectural registers through a combinational debug port. Results are forwarded into the execute stage from the three younger pipeline positions. A load whose result the next instruction needs costs one bubble. A taken branch resolves in the memory stage and turns the three instructions behind it into no-ops.

Top module: `pipe5_core`

## Requirements
- R1: An instruction word has the opcode in bits 24:22, source register A in bits 21:19, source register B in bits 18:16, the ALU destination in bits 2:0 and a 16-bit offset in bits 15:0 that is sign-extended to 32 bits. Opcode values are add=0, nand=1, load=2, store=3, branch-if-equal=4, halt=6 and no-op=7. The unused value 5 acts as a no-op.
- R2: add writes A+B into the register named by bits 2:0, and nand writes the bitwise inverse of (A and B) to the same place (A and B are the contents of the two source registers).
- R3: A load writes data word (A+offset) modulo the data-memory depth into register B. A store writes the contents of B to that same word.
- R4: When branch-if-equal finds A equal to B, the next fetch is at (branch address + 1 + offset) and the three instructions fetched after the branch have no effect. A taken branch at address 0 aimed at a halt at address 3 halts after 8 cycles. When A differs from B, execution continues in order.
- R5: An instruction that reads a register written by one of the three instructions just ahead of it receives the newest value.
- R6: An instruction that reads the register loaded by the load directly ahead of it receives the loaded value and delays completion by exactly one cycle.
- R7: A halt that reaches the write stage raises halted, which stays high. From then on the program counter holds, and neither registers nor data memory change, not even for instructions that follow the halt.
- R8: While reset is low, every register reads zero, halted is low, and the program counter returns to address 0 so that fetch restarts there.
- R9: The preload ports write any instruction or data word, and the debug port returns the current contents of the register it selects.
- R10: With no branch, stall or halt in the way, the program counter advances by one each cycle. A halt at address h behind h no-ops raises halted h+4 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_load_en | input | 1 | Write strobe for the instruction memory |
| imem_load_addr | input | IAW (6) | Instruction word address to write |
| imem_load_data | input | 32 | Instruction word to write |
| dmem_load_en | input | 1 | Write strobe for the data memory |
| dmem_load_addr | input | DAW (6) | Data word address to write |
| dmem_load_data | input | 32 | Data word to write |
| dbg_sel | input | 3 | Register selected for debug read |
| dbg_data | output | 32 | Contents of the selected register |
| halted | output | 1 | High once a halt has reached the write stage |

## Verification
The assertions assume that the core is preloaded only while it is held in reset, and that every program ends in a halt that the core actually reaches, so it never runs into unwritten memory or an endless loop. The stimulus respects this. Random programs use only forward branches with offsets of 0 to 3, and the whole tail of instruction memory after the random section is filled with halts, so every branch target lands on a real instruction or a halt. Load and store offsets are free, because addresses wrap within the data memory. A bench model executes each program one instruction at a time to produce the expected register file. Directed programs fix the cycle counts for the stall, the branch and straight-line fetch.

// File: rtl/tiny_pkg.sv
// Shared encodings and field helpers for the five-stage core.
// Assumes a 32-bit instruction word with fixed field positions.
package tiny_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 3;
    localparam int NREG = 1 << RIDX;
    localparam int IMMW = 16;
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(1);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSV  = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        FW_RF  = 2'd0,
        FW_EXM = 2'd1,
        FW_MWB = 2'd2,
        FW_WBL = 2'd3
    } fwd_e;

    localparam logic [XLEN-1:0] NOOP_WORD = {7'd0, 3'd7, 22'd0};

    function automatic op_e op_of(input logic [XLEN-1:0] w);
        return op_e'(w[24:22]);
    endfunction

    function automatic logic [RIDX-1:0] ra_of(input logic [XLEN-1:0] w);
        return w[21:19];
    endfunction

    function automatic logic [RIDX-1:0] rb_of(input logic [XLEN-1:0] w);
        return w[18:16];
    endfunction

    function automatic logic [RIDX-1:0] dst_of(input logic [XLEN-1:0] w);
        return (op_of(w) == OP_LW) ? w[18:16] : w[2:0];
    endfunction

    function automatic logic writes_rf(input logic [XLEN-1:0] w);
        return op_of(w) inside {OP_ADD, OP_NAND, OP_LW};
    endfunction

    function automatic logic reads_a(input logic [XLEN-1:0] w);
        return op_of(w) inside {OP_ADD, OP_NAND, OP_LW, OP_SW, OP_BEQ};
    endfunction

    function automatic logic reads_b(input logic [XLEN-1:0] w);
        return op_of(w) inside {OP_ADD, OP_NAND, OP_SW, OP_BEQ};
    endfunction

    function automatic logic [XLEN-1:0] imm_of(input logic [XLEN-1:0] w);
        return {{(XLEN-IMMW){w[IMMW-1]}}, w[IMMW-1:0]};
    endfunction
endpackage

// File: rtl/pipe_regfile.sv
// Architectural register file: two asynchronous read ports for decode,
// one synchronous write port for the write stage, one debug read port.
// Assumes reads see the old value when a write lands in the same cycle.
module pipe_regfile #(
    parameter int W  = 32,
    parameter int AW = 3,
    localparam int NR = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic [AW-1:0] dbg_a,
    output logic [W-1:0]  dbg_d
);
    logic [W-1:0] regs [NR];

    // Clear all registers on reset, otherwise take the write-stage result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    // Decode and debug reads.
    assign rd_a  = regs[ra_a];
    assign rd_b  = regs[ra_b];
    assign dbg_d = regs[dbg_a];
endmodule

// File: rtl/pipe_wordmem.sv
// Word-addressed array with a core write port, a preload write port and
// one asynchronous read. The core port wins on a same-address collision.
// Assumes contents are set by preload; there is no reset of the array.
module pipe_wordmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          p_we,
    input  logic [AW-1:0] p_addr,
    input  logic [W-1:0]  p_wdata,
    input  logic          s_we,
    input  logic [AW-1:0] s_addr,
    input  logic [W-1:0]  s_wdata,
    input  logic [AW-1:0] r_addr,
    output logic [W-1:0]  r_data
);
    logic [W-1:0] mem [DEPTH];

    // Preload write first, core write last so that it takes priority.
    always_ff @(posedge clk) begin
        if (s_we) mem[s_addr] <= s_wdata;
        if (p_we) mem[p_addr] <= p_wdata;
    end

    // Combinational read.
    assign r_data = mem[r_addr];
endmodule

// File: rtl/pipe_hazard.sv
// Hazard control: load-use stall, taken-branch flush and forwarding
// selects for both execute operands. Nearest producer wins.
// Assumes squashed slots carry the no-op word, so they never forward.
module pipe_hazard
    import tiny_pkg::*;
(
    input  logic [XLEN-1:0] ifid_w,
    input  logic [XLEN-1:0] idex_w,
    input  logic [XLEN-1:0] exm_w,
    input  logic [XLEN-1:0] mwb_w,
    input  logic            wbl_we,
    input  logic [RIDX-1:0] wbl_dst,
    input  logic            exm_taken,
    input  logic            stop,
    output logic            stall,
    output logic            flush,
    output fwd_e            fwd_a,
    output fwd_e            fwd_b
);
    logic load_dep;

    // Pick the youngest in-flight producer of a source register.
    function automatic fwd_e pick(input logic [RIDX-1:0] src,
                                  input logic [XLEN-1:0] e_w,
                                  input logic [XLEN-1:0] m_w,
                                  input logic l_we, input logic [RIDX-1:0] l_dst);
        if (writes_rf(e_w) && dst_of(e_w) == src) return FW_EXM;
        if (writes_rf(m_w) && dst_of(m_w) == src) return FW_MWB;
        if (l_we && l_dst == src) return FW_WBL;
        return FW_RF;
    endfunction

    // Decode needs the register a load in execute has not fetched yet.
    always_comb begin
        load_dep = 1'b0;
        if (op_of(idex_w) == OP_LW) begin
            load_dep = (reads_a(ifid_w) && ra_of(ifid_w) == rb_of(idex_w)) ||
                       (reads_b(ifid_w) && rb_of(ifid_w) == rb_of(idex_w));
        end
    end

    // Flush beats stall; a halted core does neither.
    assign flush = exm_taken && !stop;
    assign stall = load_dep && !flush && !stop;

    // Operand selects for execute.
    assign fwd_a = pick(ra_of(idex_w), exm_w, mwb_w, wbl_we, wbl_dst);
    assign fwd_b = pick(rb_of(idex_w), exm_w, mwb_w, wbl_we, wbl_dst);
endmodule

// File: rtl/pipe_execute.sv
// Execute stage: operand forwarding, ALU, branch target and equality.
// Assumes load/store address = A + offset and ALU ops use A and B.
module pipe_execute
    import tiny_pkg::*;
(
    input  logic [XLEN-1:0] idex_w,
    input  logic [XLEN-1:0] idex_pc1,
    input  logic [XLEN-1:0] rf_a,
    input  logic [XLEN-1:0] rf_b,
    input  fwd_e            fwd_a,
    input  fwd_e            fwd_b,
    input  logic [XLEN-1:0] exm_val,
    input  logic [XLEN-1:0] mwb_val,
    input  logic [XLEN-1:0] wbl_val,
    output logic [XLEN-1:0] alu,
    output logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] target,
    output logic            equal
);
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] imm;

    // Choose each operand from the register file or a younger result.
    always_comb begin
        unique case (fwd_a)
            FW_EXM:  opa = exm_val;
            FW_MWB:  opa = mwb_val;
            FW_WBL:  opa = wbl_val;
            default: opa = rf_a;
        endcase
        unique case (fwd_b)
            FW_EXM:  opb = exm_val;
            FW_MWB:  opb = mwb_val;
            FW_WBL:  opb = wbl_val;
            default: opb = rf_b;
        endcase
    end

    assign imm = imm_of(idex_w);

    // ALU: nand, address add, or register add.
    always_comb begin
        unique case (op_of(idex_w))
            OP_NAND:      alu = ~(opa & opb);
            OP_LW, OP_SW: alu = opa + imm;
            default:      alu = opa + opb;
        endcase
    end

    assign target = idex_pc1 + imm;
    assign equal  = (opa == opb);
endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core: fetch, decode, execute, memory, write.
// Memories are preloaded under reset; a halt in the write stage freezes
// every stage. Branches resolve in the memory stage.
module pipe5_core
    import tiny_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int DAW = $clog2(DMEM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imem_load_en,
    input  logic [IAW-1:0]  imem_load_addr,
    input  logic [XLEN-1:0] imem_load_data,
    input  logic            dmem_load_en,
    input  logic [DAW-1:0]  dmem_load_addr,
    input  logic [XLEN-1:0] dmem_load_data,
    input  logic [RIDX-1:0] dbg_sel,
    output logic [XLEN-1:0] dbg_data,
    output logic            halted
);
    logic [XLEN-1:0] pc_q, ifid_w, ifid_pc1;
    logic [XLEN-1:0] idex_w, idex_pc1, idex_va, idex_vb;
    logic [XLEN-1:0] exm_w, exm_alu, exm_vb, exm_tgt;
    logic            exm_taken;
    logic [XLEN-1:0] mwb_w, mwb_val;
    logic            wbl_we;
    logic [RIDX-1:0] wbl_dst;
    logic [XLEN-1:0] wbl_val;

    logic [XLEN-1:0] imem_rd, dmem_rd, rf_a, rf_b;
    logic [XLEN-1:0] ex_alu, ex_vb, ex_tgt;
    logic            ex_eq, stall, flush, stop, dmem_we;
    fwd_e            fwd_a, fwd_b;

    // A halt in the write slot stops the whole pipeline.
    assign stop    = (op_of(mwb_w) == OP_HALT);
    assign halted  = stop;
    assign dmem_we = (op_of(exm_w) == OP_SW) && !stop;

    pipe_wordmem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk(clk), .p_we(1'b0), .p_addr('0), .p_wdata('0),
        .s_we(imem_load_en), .s_addr(imem_load_addr), .s_wdata(imem_load_data),
        .r_addr(pc_q[IAW-1:0]), .r_data(imem_rd)
    );

    pipe_wordmem #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk(clk), .p_we(dmem_we), .p_addr(exm_alu[DAW-1:0]), .p_wdata(exm_vb),
        .s_we(dmem_load_en), .s_addr(dmem_load_addr), .s_wdata(dmem_load_data),
        .r_addr(exm_alu[DAW-1:0]), .r_data(dmem_rd)
    );

    pipe_regfile #(.W(XLEN), .AW(RIDX)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(writes_rf(mwb_w)), .wa(dst_of(mwb_w)), .wd(mwb_val),
        .ra_a(ra_of(ifid_w)), .ra_b(rb_of(ifid_w)), .rd_a(rf_a), .rd_b(rf_b),
        .dbg_a(dbg_sel), .dbg_d(dbg_data)
    );

    pipe_hazard u_hz (
        .ifid_w(ifid_w), .idex_w(idex_w), .exm_w(exm_w), .mwb_w(mwb_w),
        .wbl_we(wbl_we), .wbl_dst(wbl_dst), .exm_taken(exm_taken), .stop(stop),
        .stall(stall), .flush(flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    pipe_execute u_ex (
        .idex_w(idex_w), .idex_pc1(idex_pc1), .rf_a(idex_va), .rf_b(idex_vb),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .exm_val(exm_alu), .mwb_val(mwb_val), .wbl_val(wbl_val),
        .alu(ex_alu), .opb(ex_vb), .target(ex_tgt), .equal(ex_eq)
    );

    // Fetch: redirect on taken branch, hold on stall, else step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            ifid_w   <= NOOP_WORD;
            ifid_pc1 <= '0;
        end else if (!stop) begin
            if (flush) begin
                pc_q   <= exm_tgt;
                ifid_w <= NOOP_WORD;
            end else if (!stall) begin
                pc_q     <= pc_q + PC_STEP;
                ifid_w   <= imem_rd;
                ifid_pc1 <= pc_q + PC_STEP;
            end
        end
    end

    // Decode register: bubble on stall or flush, else capture operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_w   <= NOOP_WORD;
            idex_pc1 <= '0;
            idex_va  <= '0;
            idex_vb  <= '0;
        end else if (!stop) begin
            if (flush || stall) begin
                idex_w <= NOOP_WORD;
            end else begin
                idex_w   <= ifid_w;
                idex_pc1 <= ifid_pc1;
                idex_va  <= rf_a;
                idex_vb  <= rf_b;
            end
        end
    end

    // Execute register: squash on flush, else record result and branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exm_w     <= NOOP_WORD;
            exm_alu   <= '0;
            exm_vb    <= '0;
            exm_tgt   <= '0;
            exm_taken <= 1'b0;
        end else if (!stop) begin
            if (flush) begin
                exm_w     <= NOOP_WORD;
                exm_taken <= 1'b0;
            end else begin
                exm_w     <= idex_w;
                exm_alu   <= ex_alu;
                exm_vb    <= ex_vb;
                exm_tgt   <= ex_tgt;
                exm_taken <= (op_of(idex_w) == OP_BEQ) && ex_eq;
            end
        end
    end

    // Memory and write registers, plus the last-written copy for forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mwb_w   <= NOOP_WORD;
            mwb_val <= '0;
            wbl_we  <= 1'b0;
            wbl_dst <= '0;
            wbl_val <= '0;
        end else if (!stop) begin
            mwb_w   <= exm_w;
            mwb_val <= (op_of(exm_w) == OP_LW) ? dmem_rd : exm_alu;
            wbl_we  <= writes_rf(mwb_w);
            wbl_dst <= dst_of(mwb_w);
            wbl_val <= mwb_val;
        end
    end

    // Halted never drops until reset.
    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // Program counter frozen once halted.
    assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_q));

    // A load-use stall lasts exactly one cycle.
    assert_single_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // A flush leaves no-ops in the three younger slots.
    assert_squash_three_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (op_of(ifid_w) == OP_NOOP && op_of(idex_w) == OP_NOOP &&
                   op_of(exm_w) == OP_NOOP));

    // Free-running fetch steps the PC by one.
    assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !stall && !flush) |=> (pc_q == $past(pc_q) + PC_STEP));
endmodule

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;
    import tiny_pkg::*;
    localparam int ID  = 64;
    localparam int DD  = 64;
    localparam int IAW = $clog2(ID);
    localparam int DAW = $clog2(DD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic imem_load_en = 1'b0;
    logic [IAW-1:0] imem_load_addr = '0;
    logic [31:0] imem_load_data = '0;
    logic dmem_load_en = 1'b0;
    logic [DAW-1:0] dmem_load_addr = '0;
    logic [31:0] dmem_load_data = '0;
    logic [2:0] dbg_sel = '0;
    logic [31:0] dbg_data;
    logic halted;

    always #10 clk = ~clk;

    pipe5_core #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) uut (
        .clk(clk), .rst_n(rst_n),
        .imem_load_en(imem_load_en), .imem_load_addr(imem_load_addr),
        .imem_load_data(imem_load_data),
        .dmem_load_en(dmem_load_en), .dmem_load_addr(dmem_load_addr),
        .dmem_load_data(dmem_load_data),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] prog [ID];
    logic [31:0] dmi  [DD];
    logic [31:0] mrf  [8];
    logic [31:0] mdm  [DD];

    function automatic logic [31:0] enc(int op, int ra, int rb, int low);
        logic [31:0] w;
        w = {7'd0, op[2:0], ra[2:0], rb[2:0], low[15:0]};
        return w;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < ID; i++) prog[i] = enc(6, 0, 0, 0);
        for (int i = 0; i < DD; i++) dmi[i] = '0;
    endtask

    // Sequential reference: one instruction at a time, no pipeline.
    task automatic model_run();
        logic [31:0] pc, w, a, b, imm, addr, npc;
        for (int i = 0; i < 8; i++) mrf[i] = '0;
        for (int i = 0; i < DD; i++) mdm[i] = dmi[i];
        pc = '0;
        for (int step = 0; step < 1000; step++) begin
            w    = prog[pc[IAW-1:0]];
            a    = mrf[w[21:19]];
            b    = mrf[w[18:16]];
            imm  = {{16{w[15]}}, w[15:0]};
            addr = a + imm;
            npc  = pc + 1;
            if (w[24:22] == 3'd6) break;
            case (w[24:22])
                3'd0: mrf[w[2:0]] = a + b;
                3'd1: mrf[w[2:0]] = ~(a & b);
                3'd2: mrf[w[18:16]] = mdm[addr[DAW-1:0]];
                3'd3: mdm[addr[DAW-1:0]] = b;
                3'd4: if (a == b) npc = pc + 1 + imm;
                default: ;
            endcase
            pc = npc;
        end
    endtask

    task automatic check_regs(string tag);
        for (int i = 0; i < 8; i++) begin
            dbg_sel = 3'(i);
            #1;
            check(tag, $sformatf("r%0d", i), dbg_data, mrf[i]);
        end
    endtask

    // Preload under reset, check reset state, release, wait for halt.
    task automatic run_prog(string tag, output int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < ID; i++) begin
            @(negedge clk);
            imem_load_en = 1'b1;
            imem_load_addr = IAW'(i);
            imem_load_data = prog[i];
        end
        @(negedge clk);
        imem_load_en = 1'b0;
        for (int i = 0; i < DD; i++) begin
            dmem_load_en = 1'b1;
            dmem_load_addr = DAW'(i);
            dmem_load_data = dmi[i];
            @(negedge clk);
        end
        dmem_load_en = 1'b0;
        check("R8", "halted in reset", {31'd0, halted}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            dbg_sel = 3'(i);
            #1;
            check("R8", $sformatf("r%0d in reset", i), dbg_data, 32'd0);
        end
        model_run();
        @(negedge clk);
        rst_n = 1'b1;
        cycles = 0;
        while (halted !== 1'b1 && cycles < 3000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        check("R7", "halted raised", {31'd0, halted}, 32'd1);
        check_regs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc, cyc_a, cyc_b;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);

        // R2 / R5: dependencies at distances 1, 2 and 3.
        clear_all();
        dmi[1] = 32'd5; dmi[2] = 32'd9;
        prog[0] = enc(2, 0, 1, 1);
        prog[1] = enc(2, 0, 2, 2);
        prog[2] = enc(0, 1, 2, 3);
        prog[3] = enc(0, 3, 3, 4);
        prog[4] = enc(1, 3, 4, 5);
        prog[5] = enc(0, 4, 2, 6);
        prog[6] = enc(0, 4, 6, 7);
        run_prog("R5", cyc);
        dbg_sel = 3'd3; #1; check("R2", "add r3", dbg_data, 32'd14);
        dbg_sel = 3'd5; #1; check("R2", "nand r5", dbg_data, 32'hFFFF_FFF3);
        dbg_sel = 3'd7; #1; check("R5", "dist3 r7", dbg_data, 32'd65);

        // R10: straight fetch timing.
        clear_all();
        for (int i = 0; i < 5; i++) prog[i] = enc(7, 0, 0, 0);
        run_prog("R10", cyc);
        check("R10", "cycles to halt", 32'(cyc), 32'd9);

        // R6: load-use costs one cycle.
        clear_all();
        dmi[1] = 32'd5;
        prog[0] = enc(2, 0, 1, 1);
        prog[1] = enc(0, 2, 2, 3);
        run_prog("R6", cyc_a);
        prog[1] = enc(0, 1, 1, 3);
        run_prog("R6", cyc_b);
        check("R6", "independent cycles", 32'(cyc_a), 32'd6);
        check("R6", "stall extra cycle", 32'(cyc_b - cyc_a), 32'd1);
        dbg_sel = 3'd3; #1; check("R6", "loaded value used", dbg_data, 32'd10);

        // R4: taken branch squashes three, not-taken runs through.
        clear_all();
        dmi[1] = 32'd5; dmi[2] = 32'd5;
        prog[0] = enc(2, 0, 1, 1);
        prog[1] = enc(2, 0, 2, 2);
        prog[2] = enc(4, 1, 2, 3);
        prog[3] = enc(0, 1, 1, 4);
        prog[4] = enc(0, 1, 2, 5);
        prog[5] = enc(0, 2, 2, 6);
        prog[6] = enc(0, 1, 2, 7);
        run_prog("R4", cyc);
        dbg_sel = 3'd5; #1; check("R4", "squashed r5", dbg_data, 32'd0);
        dbg_sel = 3'd7; #1; check("R4", "target r7", dbg_data, 32'd10);
        dmi[2] = 32'd6;
        run_prog("R4", cyc);
        dbg_sel = 3'd6; #1; check("R4", "not taken r6", dbg_data, 32'd12);
        clear_all();
        prog[0] = enc(4, 0, 0, 2);
        prog[1] = enc(7, 0, 0, 0);
        prog[2] = enc(7, 0, 0, 0);
        run_prog("R4", cyc);
        check("R4", "taken branch cycles", 32'(cyc), 32'd8);

        // R3 / R1 / R7: store-load, address wrap, reserved opcode, post-halt.
        clear_all();
        dmi[1] = 32'd5; dmi[2] = 32'd30;
        prog[0] = enc(2, 0, 1, 1);
        prog[1] = enc(2, 0, 2, 2);
        prog[2] = enc(3, 2, 1, 3);
        prog[3] = enc(2, 0, 3, 33);
        prog[4] = enc(3, 2, 1, -40);
        prog[5] = enc(2, 0, 4, 54);
        prog[6] = enc(5, 1, 1, 7);
        prog[7] = enc(6, 0, 0, 0);
        prog[8] = enc(0, 1, 1, 5);
        prog[9] = enc(2, 0, 6, 1);
        run_prog("R3", cyc);
        dbg_sel = 3'd3; #1; check("R3", "store then load", dbg_data, 32'd5);
        dbg_sel = 3'd4; #1; check("R3", "wrapped address", dbg_data, 32'd5);
        dbg_sel = 3'd7; #1; check("R1", "opcode 5 no effect", dbg_data, 32'd0);
        repeat (6) @(negedge clk);
        check("R7", "halted stays", {31'd0, halted}, 32'd1);
        dbg_sel = 3'd5; #1; check("R7", "after-halt add", dbg_data, 32'd0);
        dbg_sel = 3'd6; #1; check("R7", "after-halt load", dbg_data, 32'd0);

        // R9 / R5: random programs against the model.
        for (int r = 0; r < 8; r++) begin
            clear_all();
            for (int i = 1; i < 8; i++)
                dmi[i] = ($urandom % 2 == 0) ? ($urandom % 4) : $urandom;
            for (int i = 8; i < DD; i++) dmi[i] = $urandom;
            for (int i = 1; i < 8; i++) prog[i-1] = enc(2, 0, i, i);
            for (int i = 7; i < 47; i++) begin
                int k, ra, rb;
                k  = int'($urandom % 10);
                ra = int'($urandom % 8);
                rb = int'($urandom % 8);
                case (k)
                    0, 1, 2: prog[i] = enc(0, ra, rb, int'($urandom % 8));
                    3, 4:    prog[i] = enc(1, ra, rb, int'($urandom % 8));
                    5:       prog[i] = enc(2, ra, rb, int'($urandom % 64));
                    6:       prog[i] = enc(3, ra, rb, int'($urandom % 64));
                    7, 8:    prog[i] = enc(4, ra, ($urandom % 3 == 0) ? ra : rb,
                                           int'($urandom % 4));
                    default: prog[i] = enc(7, 0, 0, 0);
                endcase
            end
            run_prog("R9", cyc);
            repeat (4) @(negedge clk);
            check_regs("R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule